// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit counter paired with a 16-bit capture/reload register. The counter advances either on an internal prescaled tick or on falling edges of an external count pin. One set of control bits selects what the counter is used for. In capture mode it free-runs and can snapshot its value when a second pin falls. In auto-reload mode it reloads from the register, and a pin can set the count direction. It can also produce baud ticks for a serial port, or drive a square wave with a 50% duty cycle on an output pin.

Software reaches the block through a byte-wide register port. A write takes effect on the clock edge. A read returns data one cycle after the address is presented. The overflow flag and the external-event flag are sticky and are also brought out as pins, so an interrupt controller can watch them. The transmit and receive baud ticks are one-cycle pulses, and each is routed by its own select bit.

Top module: `tmr16_multi`

## Requirements
- R1: After reset every register reads 0 and clk_out, ovf_flag, ext_flag, tx_tick and rx_tick are all 0.
- R2: Mode is chosen by priority. Run=0 is off, and the count holds even when count-pin edges arrive. Either baud select set gives baud mode. Otherwise out_en=1 with ext_src=0 gives clock-out mode. Otherwise cap_sel=1 gives capture mode, and cap_sel=0 gives auto-reload mode.
- R3: With ext_src=0 the counter takes one step every 12 clocks in capture and auto-reload modes, and one step every 2 clocks in baud and clock-out modes. The prescaler starts from zero when run is set.
- R4: With ext_src=1 the counter takes one step for each falling edge of cnt_pin, seen through a two-flop synchronizer.
- R5: In capture mode the count wraps from 0xFFFF to 0x0000 and sets the overflow flag. The reload register is left unchanged.
- R6: In capture mode with ext_en=1, a falling edge on cap_pin copies the count into the reload register and sets the external flag, and counting carries on. With ext_en=0 the same edge changes neither the reload register nor the flag.
- R7: In auto-reload mode, counting up, a step from 0xFFFF loads the reload value and sets the overflow flag.
- R8: In auto-reload mode with dir_en=1 and cap_pin low, the counter counts down. A step taken while the count equals the reload value loads 0xFFFF and sets the overflow flag. With cap_pin high, or with dir_en=0, it counts up.
- R9: In baud mode every roll-over reloads the count. The roll-over gives a one-cycle pulse on tx_tick when tx_sel=1 and on rx_tick when rx_sel=1, so the pulses are 2*(65536-reload) clocks apart. A tick whose select bit is 0 stays low, and the overflow flag is not set.
- R10: In clock-out mode clk_out toggles on each roll-over. Its high and low phases each last 2*(65536-reload) clocks, and the overflow flag is not set.
- R11: Both flags stay set until software clears them. Writing 0 to a flag bit in the control register clears it, and writing 1 leaves it as it is. A set event in the same cycle wins over the clear.
- R12: Register map. Address 0 is control: bit0 run, bit1 ext_src, bit2 cap_sel, bit3 ext_en, bit4 tx_sel, bit5 rx_sel, bit6 ext flag, bit7 overflow flag. Address 1 is setup: bit0 dir_en, bit1 out_en. Address 2 is the count low byte and address 3 the count high byte. Address 4 is the reload low byte and address 5 the reload high byte. Other addresses read 0, and rd_data is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| cnt_pin | input | 1 | External count input, asynchronous |
| cap_pin | input | 1 | Capture trigger / direction input, asynchronous |
| clk_out | output | 1 | Square-wave output |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-event flag |
| tx_tick | output | 1 | Transmit baud tick pulse |
| rx_tick | output | 1 | Receive baud tick pulse |

## Verification
The bench drives the roll-over boundaries in both directions: 0xFFFF going to the reload value or to zero, and a down-count meeting the reload value. A design that confused the two wrap rules would show the wrong count after a known number of pin pulses. Random stretches of prescaled counting are stopped at exact cycles, which catches a divider that selects the wrong ratio for the mode or that does not start from zero. Tick spacing and clk_out phase lengths are timed in clocks, and the overflow flag is checked in the quiet modes to catch a flag that is raised wrongly. Capture with ext_en cleared, and flag writes of 1, are both checked to have no effect.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [2:0] {
    M_OFF  = 3'd0,
    M_CAP  = 3'd1,
    M_RLD  = 3'd2,
    M_BAUD = 3'd3,
    M_CLK  = 3'd4
  } tmr_mode_t;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_SETUP = 3'd1;
  localparam logic [2:0] A_CNTL  = 3'd2;
  localparam logic [2:0] A_CNTH  = 3'd3;
  localparam logic [2:0] A_RLDL  = 3'd4;
  localparam logic [2:0] A_RLDH  = 3'd5;
endpackage

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign fall  = last_q & ~sh_q[STAGES-1];

  // R4: one pin transition yields a single-cycle edge pulse
  a_r4_single_fall: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int PW = $clog2(SLOW_DIV);
  localparam logic [PW-1:0] SLOW_TOP = PW'(SLOW_DIV - 1);
  localparam logic [PW-1:0] FAST_TOP = PW'(FAST_DIV - 1);

  logic [PW-1:0] pcnt_q;

  assign tick = run && (pcnt_q >= (fast ? FAST_TOP : SLOW_TOP));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) pcnt_q <= '0;
    else                     pcnt_q <= pcnt_q + 1'b1;
  end

  // R3: both divide ratios are at least two, so ticks never abut
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core import tmr16_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_mode_t        mode,
  input  logic             step_tick,
  input  logic             dir_en,
  input  logic             dir_lvl,
  input  logic             cap_fall,
  input  logic             ext_en,
  input  logic             wr_cnt_lo,
  input  logic             wr_cnt_hi,
  input  logic             wr_rld_lo,
  input  logic             wr_rld_hi,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             roll_o,
  output logic             cap_hit_o
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, rld_q, nxt, base;
  logic             step, up, at_top, at_rld;

  always_comb begin
    step      = step_tick && (mode != M_OFF);
    up        = !((mode == M_RLD) && dir_en && !dir_lvl);
    at_top    = (cnt_q == '1);
    at_rld    = (cnt_q == rld_q);
    roll_o    = step && (up ? at_top : at_rld);
    cap_hit_o = cap_fall && ext_en && (mode == M_CAP);
    if (up) nxt = at_top ? ((mode == M_CAP) ? '0 : rld_q) : cnt_q + 1'b1;
    else    nxt = at_rld ? '1 : cnt_q - 1'b1;
    base = step ? nxt : cnt_q;
    if (wr_cnt_lo) base[HALF-1:0]     = wdata;
    if (wr_cnt_hi) base[CNT_W-1:HALF] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= base;
      if (cap_hit_o) rld_q <= cnt_q;
      else begin
        if (wr_rld_lo) rld_q[HALF-1:0]     <= wdata;
        if (wr_rld_hi) rld_q[CNT_W-1:HALF] <= wdata;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  // R2: an idle counter keeps its value
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (mode == M_OFF && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_q));
  // R6: capture snapshots the count seen on the trigger cycle
  a_r6_capture_copies: assert property (@(posedge clk) disable iff (rst)
    cap_hit_o |=> (rld_q == $past(cnt_q)));
  // R8: a down step at the reload value lands on all ones
  a_r8_down_wraps: assert property (@(posedge clk) disable iff (rst)
    (step && !up && at_rld && !wr_cnt_lo && !wr_cnt_hi) |=> (cnt_q == '1));
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi import tmr16_pkg::*; #(
  parameter int CNT_W       = 16,
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic [2:0]         rd_addr,
  output logic [CNT_W/2-1:0] rd_data,
  input  logic               cnt_pin,
  input  logic               cap_pin,
  output logic               clk_out,
  output logic               ovf_flag,
  output logic               ext_flag,
  output logic               tx_tick,
  output logic               rx_tick
);
  localparam int HALF = CNT_W / 2;

  logic run_q, ext_src_q, cap_sel_q, ext_en_q, tx_sel_q, rx_sel_q;
  logic dir_en_q, out_en_q;
  logic ovf_q, ext_q, clk_q, tx_q, rx_q;
  logic [HALF-1:0] rd_q;

  tmr_mode_t mode;
  logic fast, pre_tick, cnt_lvl, cnt_fall, cap_lvl, cap_fall;
  logic step_tick, roll, cap_hit, wr_ctrl;
  logic [CNT_W-1:0] cnt, rld;

  always_comb begin
    if (!run_q)                      mode = M_OFF;
    else if (tx_sel_q || rx_sel_q)   mode = M_BAUD;
    else if (out_en_q && !ext_src_q) mode = M_CLK;
    else if (cap_sel_q)              mode = M_CAP;
    else                             mode = M_RLD;
  end

  assign fast      = (mode == M_BAUD) || (mode == M_CLK);
  assign step_tick = ext_src_q ? cnt_fall : pre_tick;
  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);

  tmr16_sync_edge #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .pin(cnt_pin), .level(cnt_lvl), .fall(cnt_fall));

  tmr16_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst(rst), .pin(cap_pin), .level(cap_lvl), .fall(cap_fall));

  tmr16_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .fast(fast), .tick(pre_tick));

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .mode(mode), .step_tick(step_tick),
    .dir_en(dir_en_q), .dir_lvl(cap_lvl), .cap_fall(cap_fall), .ext_en(ext_en_q),
    .wr_cnt_lo(wr_en && wr_addr == A_CNTL), .wr_cnt_hi(wr_en && wr_addr == A_CNTH),
    .wr_rld_lo(wr_en && wr_addr == A_RLDL), .wr_rld_hi(wr_en && wr_addr == A_RLDH),
    .wdata(wr_data), .cnt_o(cnt), .rld_o(rld), .roll_o(roll), .cap_hit_o(cap_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      {run_q, ext_src_q, cap_sel_q, ext_en_q, tx_sel_q, rx_sel_q} <= '0;
      {dir_en_q, out_en_q} <= '0;
      {ovf_q, ext_q, clk_q, tx_q, rx_q} <= '0;
      rd_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q     <= wr_data[0];
        ext_src_q <= wr_data[1];
        cap_sel_q <= wr_data[2];
        ext_en_q  <= wr_data[3];
        tx_sel_q  <= wr_data[4];
        rx_sel_q  <= wr_data[5];
      end
      if (wr_en && wr_addr == A_SETUP) begin
        dir_en_q <= wr_data[0];
        out_en_q <= wr_data[1];
      end
      if (wr_ctrl && !wr_data[7]) ovf_q <= 1'b0;
      if (roll && (mode == M_CAP || mode == M_RLD)) ovf_q <= 1'b1;
      if (wr_ctrl && !wr_data[6]) ext_q <= 1'b0;
      if (cap_hit) ext_q <= 1'b1;
      if (roll && fast && out_en_q && !ext_src_q) clk_q <= ~clk_q;
      tx_q <= roll && (mode == M_BAUD) && tx_sel_q;
      rx_q <= roll && (mode == M_BAUD) && rx_sel_q;
      case (rd_addr)
        A_CTRL:  rd_q <= HALF'({ovf_q, ext_q, rx_sel_q, tx_sel_q, ext_en_q,
                                cap_sel_q, ext_src_q, run_q});
        A_SETUP: rd_q <= HALF'({out_en_q, dir_en_q});
        A_CNTL:  rd_q <= cnt[HALF-1:0];
        A_CNTH:  rd_q <= cnt[CNT_W-1:HALF];
        A_RLDL:  rd_q <= rld[HALF-1:0];
        A_RLDH:  rd_q <= rld[CNT_W-1:HALF];
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data  = rd_q;
  assign clk_out  = clk_q;
  assign ovf_flag = ovf_q;
  assign ext_flag = ext_q;
  assign tx_tick  = tx_q;
  assign rx_tick  = rx_q;

  // R9 R10: the quiet modes never raise the overflow flag
  a_r9_quiet_flag: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_BAUD || mode == M_CLK) && !ovf_q) |=> !ovf_q);
  // R9: a transmit tick needs its select bit
  a_r9_tx_needs_sel: assert property (@(posedge clk) disable iff (rst)
    tx_q |-> $past(tx_sel_q));
  a_r9_rx_needs_sel: assert property (@(posedge clk) disable iff (rst)
    rx_q |-> $past(rx_sel_q));
  // R11: a flag only falls on a control write
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_q) |-> $past(wr_ctrl));
endmodule

// File: tb/test_tmr16_multi.sv
module test_tmr16_multi;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic cnt_pin = 1'b1, cap_pin = 1'b1;
  logic clk_out, ovf_flag, ext_flag, tx_tick, rx_tick;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tmr16_multi i_tmr16_multi (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin), .cap_pin(cap_pin),
    .clk_out(clk_out), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .tx_tick(tx_tick), .rx_tick(rx_tick));

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] r);
    wr(3'd2, c[7:0]); wr(3'd3, c[15:8]);
    wr(3'd4, r[7:0]); wr(3'd5, r[15:8]);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      cnt_pin = 1'b0; idle(3);
      cnt_pin = 1'b1; idle(3);
    end
    idle(3);
  endtask

  // {ovf, count} after k steps, from the requirement rules
  function automatic logic [16:0] model(input logic [15:0] c, input logic [15:0] r,
                                        input int k, input bit cap, input bit down);
    logic ov = 1'b0;
    for (int i = 0; i < k; i++) begin
      if (down) begin
        if (c == r) begin ov = 1'b1; c = 16'hFFFF; end
        else c = c - 16'd1;
      end else if (c == 16'hFFFF) begin
        ov = 1'b1; c = cap ? 16'h0000 : r;
      end else c = c + 16'd1;
    end
    return {ov, c};
  endfunction

  // cycles between two pulses of a tick output
  task automatic gap(input bit use_tx, output int g, output int other);
    int t0 = -1;
    g = -1; other = 0;
    for (int cyc = 0; cyc < 200 && g < 0; cyc++) begin
      @(posedge clk); #1;
      if (use_tx ? rx_tick : tx_tick) other++;
      if (use_tx ? tx_tick : rx_tick) begin
        if (t0 >= 0) g = cyc - t0;
        else t0 = cyc;
      end
    end
  endtask

  logic [7:0] b;
  logic [15:0] w;
  logic [16:0] e;
  int g, o, hi_len, lo_len;

  initial begin
    void'($urandom(32'd1357));
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), b);
      chk("R1 reg after reset", b, 8'h00);
    end
    chk("R1 outputs after reset", {clk_out, ovf_flag, ext_flag, tx_tick, rx_tick}, 5'b0);
    rd(3'd7, b);
    chk("R12 unused address", b, 8'h00);
    wr(3'd1, 8'h03); rd(3'd1, b);
    chk("R12 setup readback", b, 8'h03);
    wr(3'd1, 8'h00);

    // R2: run off, pin edges ignored
    load(16'h1234, 16'h0000);
    wr(3'd0, 8'hC2);
    pulses(4);
    rd16(3'd2, w);
    chk("R2 off holds count", w, 16'h1234);

    // R4 / R7: external count, up with reload
    load(16'hFFFE, 16'h1234);
    wr(3'd0, 8'h03);
    pulses(3);
    wr(3'd0, 8'hC2);
    rd16(3'd2, w);
    chk("R7 up reload value", w, 16'h1235);
    chk("R7 overflow flag", ovf_flag, 1'b1);

    // R11 sticky flags
    wr(3'd0, 8'hC2);
    chk("R11 writing one keeps flag", ovf_flag, 1'b1);
    wr(3'd0, 8'h42);
    rd(3'd0, b);
    chk("R11 writing zero clears", b[7], 1'b0);

    // R5 capture-mode wrap
    load(16'hFFFF, 16'h0777);
    wr(3'd0, 8'h07);
    pulses(2);
    wr(3'd0, 8'hC6);
    rd16(3'd2, w);
    chk("R5 wrap to zero", w, 16'h0001);
    rd16(3'd4, w);
    chk("R5 reload untouched", w, 16'h0777);
    chk("R5 overflow flag", ovf_flag, 1'b1);
    wr(3'd0, 8'h00);

    // R6 capture with ext_en=0 ignored
    load(16'h00A0, 16'h0555);
    wr(3'd0, 8'h07);
    cap_pin = 1'b0; idle(5); cap_pin = 1'b1; idle(5);
    rd16(3'd4, w);
    chk("R6 disabled capture reload", w, 16'h0555);
    chk("R6 disabled capture flag", ext_flag, 1'b0);
    // R6 enabled capture, counting continues
    wr(3'd0, 8'h0F);
    pulses(5);
    cap_pin = 1'b0; idle(5); cap_pin = 1'b1; idle(3);
    pulses(2);
    wr(3'd0, 8'hCE);
    rd16(3'd4, w);
    chk("R6 captured value", w, 16'h00A5);
    chk("R6 ext flag", ext_flag, 1'b1);
    rd16(3'd2, w);
    chk("R6 counting continues", w, 16'h00A7);
    wr(3'd0, 8'h00);

    // R8 down count
    cap_pin = 1'b0; idle(4);
    wr(3'd1, 8'h01);
    load(16'h0012, 16'h0010);
    wr(3'd0, 8'h03);
    pulses(3);
    wr(3'd0, 8'hC2);
    rd16(3'd2, w);
    chk("R8 down hits reload", w, 16'hFFFF);
    chk("R8 down overflow flag", ovf_flag, 1'b1);
    cap_pin = 1'b1; idle(4);
    wr(3'd0, 8'hC3);
    pulses(1);
    wr(3'd1, 8'h00);
    cap_pin = 1'b0; idle(4);
    pulses(1);
    wr(3'd0, 8'h02);
    rd16(3'd2, w);
    chk("R8 pin high then dir off counts up", w, 16'h0011);

    // R3 prescale, slow ratio, random run lengths
    wr(3'd1, 8'h00);
    for (int it = 0; it < 6; it++) begin
      int n = int'($urandom_range(0, 60));
      load(16'h0100, 16'h0000);
      wr(3'd0, 8'hC1);
      idle(n);
      wr(3'd0, 8'hC0);
      rd16(3'd2, w);
      chk("R3 slow prescale", w, 16'h0100 + 16'((n + 1) / 12));
    end
    // R3 fast ratio in clock-out mode
    wr(3'd1, 8'h02);
    for (int it = 0; it < 4; it++) begin
      int n = int'($urandom_range(0, 40));
      load(16'h0100, 16'h0000);
      wr(3'd0, 8'hC1);
      idle(n);
      wr(3'd0, 8'hC0);
      rd16(3'd2, w);
      chk("R3 fast prescale", w, 16'h0100 + 16'((n + 1) / 2));
    end

    // R10 clock out
    wr(3'd0, 8'h00);
    load(16'hFFF8, 16'hFFF8);
    wr(3'd0, 8'h01);
    b[0] = clk_out;
    while (clk_out == b[0]) idle(1);
    hi_len = 0; b[0] = clk_out;
    while (clk_out == b[0] && hi_len < 100) begin idle(1); hi_len++; end
    lo_len = 0; b[0] = clk_out;
    while (clk_out == b[0] && lo_len < 100) begin idle(1); lo_len++; end
    chk("R10 first phase", hi_len, 2 * (65536 - 16'hFFF8));
    chk("R10 second phase", lo_len, 2 * (65536 - 16'hFFF8));
    chk("R10 no overflow flag", ovf_flag, 1'b0);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    // R9 baud ticks
    load(16'hFFFE, 16'hFFFE);
    wr(3'd0, 8'h11);
    gap(1'b1, g, o);
    chk("R9 tx spacing", g, 2 * (65536 - 16'hFFFE));
    chk("R9 rx quiet", o, 0);
    wr(3'd0, 8'h00);
    load(16'hFFFA, 16'hFFFA);
    wr(3'd0, 8'h21);
    gap(1'b0, g, o);
    chk("R9 rx spacing", g, 2 * (65536 - 16'hFFFA));
    chk("R9 tx quiet", o, 0);
    chk("R9 no overflow flag", ovf_flag, 1'b0);
    wr(3'd0, 8'h00);

    // R7 / R5 random pulse runs
    cap_pin = 1'b1; idle(4);
    for (int it = 0; it < 12; it++) begin
      bit cap = 1'($urandom_range(0, 1));
      int k = int'($urandom_range(0, 10));
      logic [15:0] c = ($urandom_range(0, 1) == 1) ? 16'($urandom) : 16'hFFF8 + 16'($urandom_range(0, 7));
      logic [15:0] r = 16'($urandom);
      wr(3'd0, 8'h00);
      load(c, r);
      wr(3'd0, {5'b00000, cap, 2'b11});
      pulses(k);
      wr(3'd0, {5'b11000, cap, 2'b10});
      rd16(3'd2, w);
      e = model(c, r, k, cap, 1'b0);
      chk(cap ? "R5 random capture count" : "R7 random reload count", w, e[15:0]);
      chk(cap ? "R5 random flag" : "R7 random flag", ovf_flag, e[16]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule